// File: doc/BRIEF.md
# Cartridge Bank Mapper

The block sits between the processor's 20-bit address space and the cartridge memories. It turns an access in one of the cartridge windows into a linear ROM or SRAM address. Four bank registers supply the upper address bits, and the result is folded into the installed memory size so that accesses past the end wrap around. The SRAM window sits at 0x10000–0x1FFFF. There are three ROM windows: a small one at 0x20000–0x2FFFF, a second small one at 0x30000–0x3FFFF, and a large one that covers 0x40000–0xFFFFF.

Accesses arrive on a valid/ready request channel. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. Read data comes back on a valid/ready response channel. The response stays on the port until the consumer raises `rsp_ready`, and no new request is taken until that handshake has happened. Writes produce no response. The ROM and SRAM arrays sit outside the block. Each has a read latency of one cycle: data asked for with an enable in cycle N appears on the read-data input in cycle N+1. The bank registers are loaded through a plain select/data/strobe port.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, all four bank registers hold all ones, `req_ready` is 1, and `rsp_valid`, `rom_rd_en`, `sram_rd_en` and `sram_wr_en` are 0.
- R2: Address bits 19:16 pick the target: value 1 selects SRAM, value 2 or 3 selects a small ROM window, and values 4 through 15 select the large ROM window. Value 0 selects nothing: a read there returns 0x00 and a write there is dropped.
- R3: In the window at nibble 2, the ROM address is {bank at select code 1, addr[15:0]}. In the window at nibble 3, it is {bank at select code 2, addr[15:0]}. Both results are ANDed with `rom_mask`.
- R4: In the large window, the ROM address is {bank at select code 3, addr[19:0]} ANDed with `rom_mask`. The bank therefore lands above bit 19.
- R5: SRAM reads and writes both use the address {bank at select code 0, addr[15:0]} ANDed with `sram_mask`.
- R6: An address beyond the installed size mirrors into it through the mask, so two different window addresses can reach the same memory cell.
- R7: When `rom_present` is 0, ROM reads return 0x00 and assert no ROM enable. When `sram_present` is 0, SRAM reads return 0x00 and SRAM writes are dropped.
- R8: A write to any ROM window asserts no memory enable and produces no response.
- R9: A `cfg_we` pulse loads `cfg_wdata` into the bank chosen by `cfg_sel` (0 SRAM, 1 first small ROM window, 2 second small ROM window, 3 large ROM window). The new value applies to requests accepted in later cycles. A request accepted in the same cycle still sees the old value.
- R10: The memory enable is high for exactly one cycle, the cycle after acceptance. A read response becomes valid three cycles after the acceptance cycle. After a write, `req_ready` is high again in the next cycle.
- R11: While a read is outstanding, `req_ready` stays low. Under back-pressure, `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen, and `req_ready` returns in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_present | input | 1 | ROM is installed |
| sram_present | input | 1 | SRAM is installed |
| rom_mask | input | BANK_W+20 | Installed ROM size rounded up to a power of two, minus 1 |
| sram_mask | input | BANK_W+16 | Installed SRAM size rounded up to a power of two, minus 1 |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_sel | input | 2 | Bank register select |
| cfg_wdata | input | BANK_W | Bank register value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 20 | Processor address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read data |
| rom_rd_en | output | 1 | ROM read enable |
| rom_addr | output | BANK_W+20 | Linear ROM address |
| rom_rdata | input | DATA_W | ROM data, one cycle after the enable |
| sram_rd_en | output | 1 | SRAM read enable |
| sram_wr_en | output | 1 | SRAM write enable |
| sram_addr | output | BANK_W+16 | Linear SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM data, one cycle after the enable |

## Verification
The bench uses the default widths: 8-bit banks, which give a 28-bit ROM address and a 24-bit SRAM address. Because the masks are inputs, the bench can move them at run time. With full masks, the all-ones reset banks and the bank-above-bit-19 placement of the large window show up directly on `rom_addr`. It then shrinks the masks to 128 KiB of ROM and 32 KiB of SRAM, which brings wrap-around within reach. Under the small SRAM mask, a write through one window address is read back through an aliased one.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
  // Bank select codes on the configuration port
  localparam logic [1:0] SEL_SRAM = 2'd0;
  localparam logic [1:0] SEL_ROM0 = 2'd1;
  localparam logic [1:0] SEL_ROM1 = 2'd2;
  localparam logic [1:0] SEL_ROM2 = 2'd3;
  localparam int         NUM_BANKS = 4;

  // Region nibble (address bits 19:16)
  localparam logic [3:0] NIB_SRAM = 4'h1;
  localparam logic [3:0] NIB_ROM0 = 4'h2;
  localparam logic [3:0] NIB_ROM1 = 4'h3;

  localparam int CPU_AW = 20;
  localparam int WIN_W  = 16;

  typedef enum logic [1:0] {TGT_NONE, TGT_SRAM, TGT_ROM} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_CAPT, ST_RESP} st_e;
endpackage

// File: rtl/cbm_bank_regs.sv
`timescale 1ns/1ps
module cbm_bank_regs #(
  parameter int BANK_W = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic [1:0]                               cfg_sel,
  input  logic [BANK_W-1:0]                        cfg_wdata,
  output logic [cbm_pkg::NUM_BANKS-1:0][BANK_W-1:0] bank_q
);
  for (genvar i = 0; i < cbm_pkg::NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               bank_q[i] <= '1;
      else if (cfg_we && cfg_sel == 2'(i))      bank_q[i] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/cbm_addr_xlate.sv
`timescale 1ns/1ps
module cbm_addr_xlate
  import cbm_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic [CPU_AW-1:0]                  addr,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]   bank_q,
  input  logic [BANK_W+CPU_AW-1:0]           rom_mask,
  input  logic [BANK_W+WIN_W-1:0]            sram_mask,
  input  logic                               rom_present,
  input  logic                               sram_present,
  output tgt_e                               tgt,
  output logic [BANK_W+CPU_AW-1:0]           rom_lin,
  output logic [BANK_W+WIN_W-1:0]            sram_lin
);
  localparam int ROM_AW = BANK_W + CPU_AW;

  logic [3:0]        nib;
  logic [ROM_AW-1:0] rom_raw;

  assign nib = addr[CPU_AW-1:WIN_W];

  always_comb begin
    if (nib == NIB_ROM0)
      rom_raw = ROM_AW'({bank_q[SEL_ROM0], addr[WIN_W-1:0]});
    else if (nib == NIB_ROM1)
      rom_raw = ROM_AW'({bank_q[SEL_ROM1], addr[WIN_W-1:0]});
    else
      rom_raw = {bank_q[SEL_ROM2], addr};
  end

  assign rom_lin  = rom_raw & rom_mask;
  assign sram_lin = {bank_q[SEL_SRAM], addr[WIN_W-1:0]} & sram_mask;

  always_comb begin
    if (nib == NIB_SRAM)      tgt = sram_present ? TGT_SRAM : TGT_NONE;
    else if (nib >= NIB_ROM0) tgt = rom_present  ? TGT_ROM  : TGT_NONE;
    else                      tgt = TGT_NONE;
  end
endmodule

// File: rtl/cbm_access_ctrl.sv
`timescale 1ns/1ps
module cbm_access_ctrl
  import cbm_pkg::*;
#(
  parameter int ROM_AW  = 28,
  parameter int SRAM_AW = 24,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  input  tgt_e               tgt,
  input  logic [ROM_AW-1:0]  rom_lin,
  input  logic [SRAM_AW-1:0] sram_lin,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rom_rd_en,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic [DATA_W-1:0]  rom_rdata,
  output logic               sram_rd_en,
  output logic               sram_wr_en,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  input  logic [DATA_W-1:0]  sram_rdata
);
  st_e  state;
  tgt_e tgt_q;
  logic accept;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tgt_q      <= TGT_NONE;
      rom_rd_en  <= 1'b0;
      sram_rd_en <= 1'b0;
      sram_wr_en <= 1'b0;
      rom_addr   <= '0;
      sram_addr  <= '0;
      sram_wdata <= '0;
      rsp_data   <= '0;
    end else begin
      rom_rd_en  <= 1'b0;
      sram_rd_en <= 1'b0;
      sram_wr_en <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          rom_addr   <= rom_lin;
          sram_addr  <= sram_lin;
          sram_wdata <= req_wdata;
          if (req_write) begin
            sram_wr_en <= (tgt == TGT_SRAM);
          end else begin
            rom_rd_en  <= (tgt == TGT_ROM);
            sram_rd_en <= (tgt == TGT_SRAM);
            tgt_q      <= tgt;
            state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_CAPT;
        ST_CAPT: begin
          unique case (tgt_q)
            TGT_ROM:  rsp_data <= rom_rdata;
            TGT_SRAM: rsp_data <= sram_rdata;
            default:  rsp_data <= '0;
          endcase
          state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_mapper.sv
`timescale 1ns/1ps
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rom_present,
  input  logic                      sram_present,
  input  logic [BANK_W+20-1:0]      rom_mask,
  input  logic [BANK_W+16-1:0]      sram_mask,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [BANK_W-1:0]         cfg_wdata,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [19:0]               req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [DATA_W-1:0]         rsp_data,
  output logic                      rom_rd_en,
  output logic [BANK_W+20-1:0]      rom_addr,
  input  logic [DATA_W-1:0]         rom_rdata,
  output logic                      sram_rd_en,
  output logic                      sram_wr_en,
  output logic [BANK_W+16-1:0]      sram_addr,
  output logic [DATA_W-1:0]         sram_wdata,
  input  logic [DATA_W-1:0]         sram_rdata
);
  localparam int ROM_AW  = BANK_W + CPU_AW;
  localparam int SRAM_AW = BANK_W + WIN_W;

  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;
  tgt_e                             tgt;
  logic [ROM_AW-1:0]                rom_lin;
  logic [SRAM_AW-1:0]               sram_lin;

  cbm_bank_regs #(.BANK_W(BANK_W)) u_banks (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .bank_q
  );

  cbm_addr_xlate #(.BANK_W(BANK_W)) u_xlate (
    .addr(req_addr), .bank_q, .rom_mask, .sram_mask,
    .rom_present, .sram_present, .tgt, .rom_lin, .sram_lin
  );

  cbm_access_ctrl #(.ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW), .DATA_W(DATA_W)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_wdata,
    .tgt, .rom_lin, .sram_lin, .rsp_valid, .rsp_ready, .rsp_data,
    .rom_rd_en, .rom_addr, .rom_rdata, .sram_rd_en, .sram_wr_en,
    .sram_addr, .sram_wdata, .sram_rdata
  );
endmodule

// File: rtl/cbm_checker.sv
`timescale 1ns/1ps
module cbm_checker #(
  parameter int BANK_W = 8,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_write,
  input logic [19:0]             req_addr,
  input logic                    rom_present,
  input logic                    rom_rd_en,
  input logic                    sram_rd_en,
  input logic                    sram_wr_en,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [DATA_W-1:0]       rsp_data,
  input logic                    cfg_we,
  input logic [1:0]              cfg_sel,
  input logic [BANK_W-1:0]       cfg_wdata,
  input logic [3:0][BANK_W-1:0]  bank_q
);
  logic rom_hit;
  assign rom_hit = req_valid && req_ready && (req_addr[19:16] >= 4'h2);

  // R11: response held under back-pressure
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R11: no new request while a response waits
  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10: at most one memory strobe per cycle, and reads only while busy
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd_en, sram_rd_en, sram_wr_en}));
  a_r10_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd_en || sram_rd_en) |-> !req_ready);

  // R10: ROM read issued the cycle after a present-ROM read is accepted
  a_r10_rom_issue: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit && !req_write && rom_present |=> rom_rd_en);

  // R8: writes into ROM windows strobe nothing
  a_r8_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit && req_write |=> !sram_wr_en && !rom_rd_en);

  // R7: absent ROM is never read
  a_r7_absent_rom: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit && !rom_present |=> !rom_rd_en);

  // R9: bank port loads in one cycle
  a_r9_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> bank_q[$past(cfg_sel)] == $past(cfg_wdata));
endmodule

bind cart_bank_mapper cbm_checker #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rom_present(rom_present),
  .rom_rd_en(rom_rd_en), .sram_rd_en(sram_rd_en), .sram_wr_en(sram_wr_en),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bank_q(bank_q)
);

// File: tb/cart_bank_mapper_bench.sv
`timescale 1ns/1ps
module cart_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rom_present = 1'b1, sram_present = 1'b1;
  logic [27:0] rom_mask = 28'hFFF_FFFF;
  logic [23:0] sram_mask = 24'hFF_FFFF;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rom_rd_en, sram_rd_en, sram_wr_en;
  logic [7:0]  rsp_data, sram_wdata;
  logic [7:0]  rom_rdata = '0, sram_rdata = '0;
  logic [27:0] rom_addr;
  logic [23:0] sram_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_bank_mapper u_cart_bank_mapper (.*);

  // ---------------- memory models ----------------
  function automatic logic [7:0] rom_pat(logic [27:0] x);
    return x[7:0] ^ x[15:8] ^ x[23:16] ^ {4'h0, x[27:24]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] sram_pat(logic [23:0] x);
    return x[7:0] ^ x[15:8] ^ x[23:16] ^ 8'hC3;
  endfunction

  logic [7:0] sram_mem [int];
  always @(posedge clk) begin
    if (rom_rd_en) rom_rdata <= rom_pat(rom_addr);
    if (sram_rd_en) sram_rdata <= sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : sram_pat(sram_addr);
    if (sram_wr_en) sram_mem[int'(sram_addr)] = sram_wdata;
  end

  // ---------------- reference model ----------------
  logic [7:0] ref_bank [4] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};
  logic [7:0] ref_sram [int];
  logic [27:0] q_rom[$];
  logic [23:0] q_srd[$];
  logic [31:0] q_swr[$];

  function automatic logic [27:0] ref_rom(logic [19:0] a);
    logic [27:0] r;
    if (a[19:16] == 4'h2)      r = {4'h0, ref_bank[1], a[15:0]};
    else if (a[19:16] == 4'h3) r = {4'h0, ref_bank[2], a[15:0]};
    else                       r = {ref_bank[3], a};
    return r & rom_mask;
  endfunction
  function automatic logic [23:0] ref_sr(logic [19:0] a);
    return {ref_bank[0], a[15:0]} & sram_mask;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison of memory strobes against the reference queues
  always @(negedge clk) if (rst_n && !done) begin
    if (rom_rd_en) begin
      if (q_rom.size() == 0) chk(0, "R7/R8", "unexpected rom_rd_en", 1, 0);
      else begin
        logic [27:0] e; e = q_rom.pop_front();
        chk(rom_addr == e, "R3/R4/R6", "rom_addr", rom_addr, e);
      end
    end
    if (sram_rd_en) begin
      if (q_srd.size() == 0) chk(0, "R7", "unexpected sram_rd_en", 1, 0);
      else begin
        logic [23:0] e; e = q_srd.pop_front();
        chk(sram_addr == e, "R5/R6", "sram read addr", sram_addr, e);
      end
    end
    if (sram_wr_en) begin
      if (q_swr.size() == 0) chk(0, "R2/R7/R8", "unexpected sram_wr_en", 1, 0);
      else begin
        logic [31:0] e; e = q_swr.pop_front();
        chk({sram_addr, sram_wdata} == e, "R5/R6", "sram write", {sram_addr, sram_wdata}, e);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(posedge clk);
    ref_bank[s] = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_read(input logic [19:0] a, input string tag, input int hold,
                         input bit cw, input logic [1:0] cs, input logic [7:0] cv);
    logic [7:0] exp_d;
    int n;
    if (a[19:16] == 4'h1 && sram_present) begin
      logic [23:0] sa; sa = ref_sr(a);
      q_srd.push_back(sa);
      exp_d = ref_sram.exists(int'(sa)) ? ref_sram[int'(sa)] : sram_pat(sa);
    end else if (a[19:16] >= 4'h2 && rom_present) begin
      logic [27:0] ra; ra = ref_rom(a);
      q_rom.push_back(ra);
      exp_d = rom_pat(ra);
    end else exp_d = 8'h00;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "req_ready before read", req_ready, 1);
    req_valid = 1; req_write = 0; req_addr = a;
    if (cw) begin cfg_we = 1; cfg_sel = cs; cfg_wdata = cv; end
    @(posedge clk);
    if (cw) ref_bank[cs] = cv;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk(req_ready == 1'b0, "R11", "req_ready while busy", req_ready, 0);
    n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk(n == 2, "R10", "response latency after issue", n, 2);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == exp_d && !req_ready, "R11", "held response",
          {rsp_valid, rsp_data}, {1'b1, exp_d});
    end
    rsp_ready = 1;
    chk(rsp_data == exp_d, tag, $sformatf("read data @%05h", a), rsp_data, exp_d);
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready && !rsp_valid, "R11", "ready after handshake", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d, input string tag);
    if (a[19:16] == 4'h1 && sram_present) begin
      logic [23:0] sa; sa = ref_sr(a);
      q_swr.push_back({sa, d});
      ref_sram[int'(sa)] = d;
    end
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(req_ready && !rsp_valid, tag, "ready after write, no response", {req_ready, rsp_valid}, 2'b10);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !rom_rd_en && !sram_rd_en && !sram_wr_en, "R1",
        "idle outputs in reset", {req_ready, rsp_valid, rom_rd_en, sram_rd_en, sram_wr_en}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1", "idle after reset", {req_ready, rsp_valid}, 2'b10);

    // R1: reset banks all ones
    do_read(20'h2ABCD, "R1", 0, 0, 0, 0);
    do_read(20'h9ABCD, "R1", 0, 0, 0, 0);
    do_read(20'h1ABCD, "R1", 0, 0, 0, 0);

    // R9: load banks
    cfg_write(2'd0, 8'h02);
    cfg_write(2'd1, 8'h03);
    cfg_write(2'd2, 8'h47);
    cfg_write(2'd3, 8'h05);

    // R3 / R4 / R2 window decode
    do_read(20'h21234, "R3", 0, 0, 0, 0);
    do_read(20'h3FFFF, "R3", 0, 0, 0, 0);
    do_read(20'h40010, "R4", 0, 0, 0, 0);
    do_read(20'hFEDCB, "R4", 1, 0, 0, 0);
    do_read(20'h1ABCD, "R5", 0, 0, 0, 0);

    // R5 write/read, R11 back-pressure
    do_write(20'h10055, 8'hA5, "R5");
    do_read(20'h10055, "R5", 3, 0, 0, 0);

    // R2: nibble 0 hits nothing
    do_read(20'h05555, "R2", 0, 0, 0, 0);
    do_write(20'h05555, 8'h77, "R2");

    // R8: writes into ROM windows
    do_write(20'h21234, 8'h11, "R8");
    do_write(20'h40000, 8'h22, "R8");
    do_read(20'h21234, "R8", 0, 0, 0, 0);

    // R6: mirroring under small masks
    rom_mask = 28'h001_FFFF; sram_mask = 24'h00_7FFF;
    do_read(20'h30100, "R6", 0, 0, 0, 0);
    do_read(20'hC0000, "R6", 0, 0, 0, 0);
    do_write(20'h19000, 8'h3C, "R6");
    do_read(20'h11000, "R6", 0, 0, 0, 0);

    // R9: same-cycle update keeps the old bank, next request sees new
    do_read(20'h2ABCD, "R9", 0, 1, 2'd1, 8'h12);
    do_read(20'h2ABCD, "R9", 0, 0, 0, 0);

    // R7: absent memories
    rom_present = 0;
    do_read(20'h2ABCD, "R7", 0, 0, 0, 0);
    do_read(20'h80000, "R7", 0, 0, 0, 0);
    rom_present = 1;
    sram_present = 0;
    do_write(20'h10055, 8'hFF, "R7");
    do_read(20'h10055, "R7", 0, 0, 0, 0);
    sram_present = 1;
    do_read(20'h10055, "R7", 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    chk(q_rom.size() + q_srd.size() + q_swr.size() == 0, "R10", "all expected strobes seen",
        q_rom.size() + q_srd.size() + q_swr.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 50000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule